// File: doc/BRIEF.md
# Cascaded-Device SRAM Read Sequencer

This block sits in each device of a cascade that shares one host command/data bus and one set of off-chip SRAM strobes. The host issues an SRAM read as two consecutive command cycles (half A, then half B), each marked by a command-valid strobe. Every device in the cascade watches these cycles. Only the device whose strapped identifier equals the ID field carried on the data bus in half A accepts the read. That device then runs a fixed timeline and releases every shared line again.

The selected device first leaves the data bus alone for two turnaround cycles while the host lets go of it. It then drives response data for three cycles and runs the acknowledge line through low, high and low. In the middle cycle of that window it presents the SRAM address and asserts the chip-enable and address-latch strobes, with write-enable held inactive. Shared lines are modelled as a value plus an output-enable, so the pads stay outside the block. All other devices keep their enables off.

Top module: `sram_rd_seq`

## Requirements
- R1: A read is accepted only if `cmd_valid` is high and `cmd_op` equals the read opcode (parameter `READ_OP`, default 2'b01) in two consecutive cycles. If half B fails this test, no enable is ever raised for that command.
- R2: In both halves, `dq_in[20:19]` must be 2'b10 (SRAM access tag). Any other value in either half means no sequence is started.
- R3: The device is selected only when `dq_in[25:21]` equals `dev_id` in half A. A device that is not selected keeps `dq_oe`, `ack_oe`, `sadr_oe` and `strobe_oe` low.
- R4: In cycles 2 and 3 (the two cycles after half B), every output-enable stays low.
- R5: In cycles 4, 5 and 6, `dq_oe` is high and `dq_out` carries `rsp_data` as sampled at the preceding clock edge.
- R6: `ack_oe` is high in cycles 5, 6 and 7. `ack_out` is low in cycles 5 and 7 and high in cycle 6.
- R7: In cycle 6 only, `sadr_oe` and `strobe_oe` are high. `sadr` = {`cmd_hi` from half A, `dq_in[18:0]` from half A}, `ce_n` = 0, `ale_n` = 0 and `we_n` = 1.
- R8: In cycle 7, `dq_oe`, `sadr_oe` and `strobe_oe` are low. From the cycle after cycle 7 all enables are low, and a new half A may be presented in that same cycle.
- R9: A command presented while a sequence is running is ignored and does not change the running sequence's timing or values.
- R10: Synchronous active-high `rst` returns the block to idle, with all enables low after the next clock edge, including in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_id | input | 5 | Strapped device identifier |
| cmd_valid | input | 1 | Command-valid strobe |
| cmd_op | input | 2 | Command opcode |
| cmd_hi | input | 3 | Upper SRAM address bits, valid in half A |
| dq_in | input | 68 | Data bus as seen by the device |
| rsp_data | input | 68 | Response data to place on the data bus |
| dq_out | output | 68 | Data bus drive value |
| dq_oe | output | 1 | Data bus drive enable |
| ack_out | output | 1 | Acknowledge drive value |
| ack_oe | output | 1 | Acknowledge drive enable |
| sadr | output | 22 | SRAM address drive value |
| sadr_oe | output | 1 | SRAM address drive enable |
| ce_n | output | 1 | SRAM chip enable, active low |
| we_n | output | 1 | SRAM write enable, active low |
| ale_n | output | 1 | SRAM address latch enable, active low |
| strobe_oe | output | 1 | Drive enable for ce_n, we_n, ale_n |

## Verification
A wrong sequencer state shows as an output-enable rising in the wrong cycle: in a turnaround cycle, it would collide with the host. A misplaced acknowledge edge or a strobe pulse that sits outside cycle 6 shows up on the first clock edge after the faulty transition. A device that accepts a command with a mismatched ID, tag or opcode raises `dq_oe` exactly three edges after half B. A sequence that a mid-sequence command wrongly restarts stretches the enable window visibly. A bad address capture is only visible in the single cycle 6, so every accepted read compares `sadr` there.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HALFB = 3'd1,
    ST_TURN1 = 3'd2,
    ST_TURN2 = 3'd3,
    ST_DATA  = 3'd4,
    ST_ACK   = 3'd5,
    ST_ADDR  = 3'd6,
    ST_REL   = 3'd7
  } seq_st_t;

  localparam int TAG_LSB = 19;
  localparam int ID_LSB  = 21;
  localparam logic [1:0] TAG_SRAM = 2'b10;
endpackage

// File: rtl/sram_rd_decode.sv
module sram_rd_decode #(
  parameter int DQ_W = 68,
  parameter int ID_W = 5,
  parameter int OP_W = 2,
  parameter logic [OP_W-1:0] READ_OP = 2'b01
) (
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic [DQ_W-1:0] dq_in,
  input  logic [ID_W-1:0] dev_id,
  output logic            half_ok,
  output logic            id_hit
);
  import sram_rd_pkg::*;

  logic [1:0]      tag;
  logic [ID_W-1:0] id_fld;

  always_comb begin
    tag     = dq_in[TAG_LSB +: 2];
    id_fld  = dq_in[ID_LSB +: ID_W];
    half_ok = cmd_valid && (cmd_op == READ_OP) && (tag == TAG_SRAM);
    id_hit  = (id_fld == dev_id);
  end
endmodule

// File: rtl/sram_rd_fsm.sv
module sram_rd_fsm (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   half_ok,
  input  logic                   id_hit,
  output sram_rd_pkg::seq_st_t   st_nxt,
  output logic                   load_a
);
  import sram_rd_pkg::*;

  seq_st_t st;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:  if (half_ok && id_hit) st_nxt = ST_HALFB;
      ST_HALFB: st_nxt = half_ok ? ST_TURN1 : ST_IDLE;
      ST_TURN1: st_nxt = ST_TURN2;
      ST_TURN2: st_nxt = ST_DATA;
      ST_DATA:  st_nxt = ST_ACK;
      ST_ACK:   st_nxt = ST_ADDR;
      ST_ADDR:  st_nxt = ST_REL;
      ST_REL:   st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
    load_a = (st == ST_IDLE) && (st_nxt == ST_HALFB);
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/sram_rd_drive.sv
module sram_rd_drive #(
  parameter int DQ_W   = 68,
  parameter int SADR_W = 22,
  parameter int HI_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  sram_rd_pkg::seq_st_t st_nxt,
  input  logic                 load_a,
  input  logic [HI_W-1:0]      cmd_hi,
  input  logic [DQ_W-1:0]      dq_in,
  input  logic [DQ_W-1:0]      rsp_data,
  output logic [DQ_W-1:0]      dq_out,
  output logic                 dq_oe,
  output logic                 ack_out,
  output logic                 ack_oe,
  output logic [SADR_W-1:0]    sadr,
  output logic                 sadr_oe,
  output logic                 ce_n,
  output logic                 we_n,
  output logic                 ale_n,
  output logic                 strobe_oe
);
  import sram_rd_pkg::*;

  localparam int LO_W = SADR_W - HI_W;

  logic [SADR_W-1:0] addr_q;
  logic              nx_data, nx_ack, nx_addr;

  always_comb begin
    nx_data = (st_nxt == ST_DATA) || (st_nxt == ST_ACK) || (st_nxt == ST_ADDR);
    nx_ack  = (st_nxt == ST_ACK) || (st_nxt == ST_ADDR) || (st_nxt == ST_REL);
    nx_addr = (st_nxt == ST_ADDR);
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (load_a) addr_q <= {cmd_hi, dq_in[LO_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      ack_out   <= 1'b0;
      ack_oe    <= 1'b0;
      sadr      <= '0;
      sadr_oe   <= 1'b0;
      ce_n      <= 1'b1;
      we_n      <= 1'b1;
      ale_n     <= 1'b1;
      strobe_oe <= 1'b0;
    end else begin
      dq_out    <= nx_data ? rsp_data : '0;
      dq_oe     <= nx_data;
      ack_out   <= nx_addr;
      ack_oe    <= nx_ack;
      sadr      <= nx_addr ? addr_q : '0;
      sadr_oe   <= nx_addr;
      ce_n      <= !nx_addr;
      we_n      <= 1'b1;
      ale_n     <= !nx_addr;
      strobe_oe <= nx_addr;
    end
  end
endmodule

// File: rtl/sram_rd_seq.sv
module sram_rd_seq #(
  parameter int DQ_W   = 68,
  parameter int ID_W   = 5,
  parameter int OP_W   = 2,
  parameter int SADR_W = 22,
  parameter int HI_W   = 3,
  parameter logic [OP_W-1:0] READ_OP = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [HI_W-1:0]   cmd_hi,
  input  logic [DQ_W-1:0]   dq_in,
  input  logic [DQ_W-1:0]   rsp_data,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              ack_out,
  output logic              ack_oe,
  output logic [SADR_W-1:0] sadr,
  output logic              sadr_oe,
  output logic              ce_n,
  output logic              we_n,
  output logic              ale_n,
  output logic              strobe_oe
);
  import sram_rd_pkg::*;

  logic    half_ok, id_hit, load_a;
  seq_st_t st_nxt;

  sram_rd_decode #(.DQ_W(DQ_W), .ID_W(ID_W), .OP_W(OP_W), .READ_OP(READ_OP)) u_dec (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .dq_in(dq_in), .dev_id(dev_id),
    .half_ok(half_ok), .id_hit(id_hit)
  );

  sram_rd_fsm u_fsm (
    .clk(clk), .rst(rst), .half_ok(half_ok), .id_hit(id_hit),
    .st_nxt(st_nxt), .load_a(load_a)
  );

  sram_rd_drive #(.DQ_W(DQ_W), .SADR_W(SADR_W), .HI_W(HI_W)) u_drv (
    .clk(clk), .rst(rst), .st_nxt(st_nxt), .load_a(load_a),
    .cmd_hi(cmd_hi), .dq_in(dq_in), .rsp_data(rsp_data),
    .dq_out(dq_out), .dq_oe(dq_oe), .ack_out(ack_out), .ack_oe(ack_oe),
    .sadr(sadr), .sadr_oe(sadr_oe), .ce_n(ce_n), .we_n(we_n), .ale_n(ale_n),
    .strobe_oe(strobe_oe)
  );
endmodule

// File: rtl/sram_rd_seq_chk.sv
module sram_rd_seq_chk (
  input logic clk,
  input logic rst,
  input logic dq_oe,
  input logic ack_out,
  input logic ack_oe,
  input logic sadr_oe,
  input logic ce_n,
  input logic we_n,
  input logic ale_n,
  input logic strobe_oe
);
  AST_ACK_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |=> $rose(ack_oe) && !ack_out); // R6

  AST_STROBE_PATTERN: assert property (@(posedge clk) disable iff (rst)
    strobe_oe |-> sadr_oe && dq_oe && ack_oe && ack_out && !ce_n && !ale_n && we_n); // R7

  AST_RELEASE_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
    strobe_oe |=> !strobe_oe && !sadr_oe && !dq_oe && ack_oe && !ack_out); // R8

  AST_ACK_FLOATS: assert property (@(posedge clk) disable iff (rst)
    (ack_oe && !ack_out && !dq_oe) |=> !ack_oe); // R8

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !dq_oe && !ack_oe && !sadr_oe && !strobe_oe); // R10
endmodule

bind sram_rd_seq sram_rd_seq_chk u_chk (.*);

// File: tb/test_sram_rd_seq.sv
module test_sram_rd_seq;
  localparam int CLK_P = 10;
  localparam logic [1:0] RD = 2'b01;
  localparam logic [4:0] MY_ID = 5'd9;

  typedef struct {
    logic        dq_oe;
    logic [67:0] dq;
    logic        ack_oe;
    logic        ack;
    logic        s_oe;
    logic [21:0] sadr;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] dev_id = MY_ID;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [2:0] cmd_hi = '0;
  logic [67:0] dq_in = '0, rsp_data = '0;
  logic [67:0] dq_out;
  logic dq_oe, ack_out, ack_oe, sadr_oe, ce_n, we_n, ale_n, strobe_oe;
  logic [21:0] sadr;

  int vectors = 0, fails = 0;
  bit done = 0;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  sram_rd_seq i_sram_rd_seq (.*);

  function automatic exp_t mk(input int c, input bit hit, input logic [21:0] a,
                              input logic [67:0] d, input string tag);
    exp_t e;
    e.dq_oe  = hit && c >= 4 && c <= 6;
    e.dq     = d;
    e.ack_oe = hit && c >= 5 && c <= 7;
    e.ack    = (c == 6);
    e.s_oe   = hit && c == 6;
    e.sadr   = a;
    e.tag    = tag;
    return e;
  endfunction

  // monitor: compares after the registered outputs settle
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      vectors++;
      bad = 0;
      if (dq_oe !== e.dq_oe || (e.dq_oe && dq_out !== e.dq)) begin
        bad = 1;
        $display("FAIL %s dq_oe=%b dq=%h expected dq_oe=%b dq=%h", e.tag, dq_oe, dq_out, e.dq_oe, e.dq);
      end
      if (ack_oe !== e.ack_oe || (e.ack_oe && ack_out !== e.ack)) begin
        bad = 1;
        $display("FAIL %s ack_oe=%b ack=%b expected ack_oe=%b ack=%b", e.tag, ack_oe, ack_out, e.ack_oe, e.ack);
      end
      if (sadr_oe !== e.s_oe || strobe_oe !== e.s_oe ||
          (e.s_oe && (sadr !== e.sadr || ce_n !== 1'b0 || ale_n !== 1'b0 || we_n !== 1'b1))) begin
        bad = 1;
        $display("FAIL %s sadr_oe=%b strobe_oe=%b sadr=%h ce/we/ale=%b%b%b expected oe=%b sadr=%h ce/we/ale=010",
                 e.tag, sadr_oe, strobe_oe, sadr, ce_n, we_n, ale_n, e.s_oe, e.sadr);
      end
      if (bad) fails++;
    end
  end

  // mode: 0 good, 1 ID miss, 2 bad tag half A, 3 bad tag half B,
  //       4 wrong opcode half B, 5 no valid half B, 6 good with intruding command
  task automatic rd(input logic [21:0] a, input logic [67:0] d, input int mode, input int rst_at);
    bit hit;
    string tg;
    hit = (mode == 0 || mode == 6);
    case (mode)
      1: tg = "R3";
      2, 3: tg = "R2";
      4, 5: tg = "R1";
      default: tg = "";
    endcase
    for (int j = 0; j < 8; j++) begin
      string t;
      int c;
      @(negedge clk);
      c = j + 1;
      rsp_data = d;
      cmd_valid = 1'b0;
      cmd_op = '0;
      dq_in = '0;
      cmd_hi = '0;
      if (j == 0 || (mode == 6 && (j == 2 || j == 3))) begin
        cmd_valid = 1'b1;
        cmd_op = RD;
        dq_in[18:0] = (j == 0) ? a[18:0] : ~a[18:0];
        dq_in[20:19] = (mode == 2 && j == 0) ? 2'b01 : 2'b10;
        dq_in[25:21] = (mode == 1) ? (MY_ID ^ 5'd4) : MY_ID;
        cmd_hi = (j == 0) ? a[21:19] : ~a[21:19];
      end else if (j == 1) begin
        cmd_valid = (mode == 5) ? 1'b0 : 1'b1;
        cmd_op = (mode == 4) ? 2'b10 : RD;
        dq_in[20:19] = (mode == 3) ? 2'b11 : 2'b10;
        dq_in[25:21] = MY_ID;
      end
      if (tg != "") t = tg;
      else if (mode == 6) t = "R9";
      else if (c <= 3) t = "R4";
      else if (c == 4) t = "R5";
      else if (c == 6) t = "R7";
      else if (c == 8) t = "R8";
      else t = "R6";
      if (rst_at == j) begin
        rst = 1'b1;
        q.push_back(mk(0, 0, a, d, "R10"));
        @(negedge clk);
        rst = 1'b0;
        cmd_valid = 1'b0;
        q.push_back(mk(0, 0, a, d, "R10"));
        return;
      end
      q.push_back(mk(c, hit, a, d, t));
    end
  endtask

  initial begin
    @(negedge clk);
    q.push_back(mk(0, 0, '0, '0, "R10"));
    @(negedge clk);
    rst = 1'b0;
    rd(22'h2A5A5A, {4'hC, 64'h0123_4567_89AB_CDEF}, 0, -1);
    rd(22'h1FFFFF, {68{1'b1}}, 0, -1);             // back-to-back, R8
    rd(22'h000001, 68'h5, 1, -1);
    rd(22'h3C0F0F, 68'h6, 2, -1);
    rd(22'h155555, 68'h7, 3, -1);
    rd(22'h0AAAAA, 68'h8, 4, -1);
    rd(22'h123456, 68'h9, 5, -1);
    rd(22'h3ABCDE, 68'hF_0F0F_0F0F_0F0F_0F0F, 6, -1);
    rd(22'h2468AC, 68'hA, 0, 4);                   // reset mid-sequence, R10
    rd(22'h13579B, 68'hB, 0, -1);                  // works again after reset
    rd(22'h380000, 68'h0, 0, -1);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule